// File: doc/BRIEF.md
# Interleaved Rank Stream Filter

This block picks one order statistic out of a sliding window of five unsigned samples and delivers it at the full sample rate. A single bit-serial rank selector needs one clock per sample bit to resolve its answer, so on its own it could produce a result only once every `W` clocks. Here `W` identical selector units run side by side. Each new window goes to the next unit in a fixed rotation, and each finished result comes back through a one-hot multiplexer. Once the pipeline is full, one ranked value leaves the block on every clock.

Samples arrive on a valid/ready stream together with a rank setting, and ranked values leave on a second valid/ready stream. Back-pressure is global. While `out_ready` is low, `in_ready` is low as well, and every register in the block holds its value: the window, the rotation pointer, every unit's progress and the output. A result that is on offer stays on offer, unchanged, until it is taken. Idle cycles on the input (`in_valid` low) do not disturb the window. They only delay the next window.

Top module: `rank_stream_filter`

## Requirements
- R1: For each accepted sample that completes a window, the block outputs the rank-th smallest of the five most recently accepted samples, compared as unsigned values. Rank 1 is the minimum, rank 3 is the median and rank 5 is the maximum.
- R2: A rank value of 0 is treated as 1. Any rank value above 5 (6 or 7 on the 3-bit port) is treated as 5.
- R3: With `out_ready` held high, the result for a window appears on `out_valid`/`out_data` exactly `W`+1 clocks after the clock edge that accepted the sample completing that window.
- R4: Windows formed on consecutive clocks produce results on consecutive clocks, in window order, with none dropped. The units are used in a fixed rotation, and at most one unit finishes in any cycle.
- R5: After reset, no result is produced until five samples have been accepted. An idle input cycle does not clear the partly or fully filled window.
- R6: `in_ready` equals `out_ready`. While `out_ready` is low, no sample is accepted, no unit advances, and a pending `out_valid`/`out_data` pair is held stable.
- R7: Reset discards any samples already in the window and any windows in flight, so only samples accepted after reset contribute to results.
- R8: The rank applied to a window is the rank presented with the sample that completes that window. A later change of rank does not affect windows already formed.
- R9: Windows holding repeated values return the correct order statistic. This includes windows whose five values are all equal and windows containing both 0 and the full-scale value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be taken (mirrors out_ready) |
| in_data | input | W | Unsigned sample |
| in_rank | input | $clog2(N+1) | Order statistic wanted, 1 = smallest |
| out_valid | output | 1 | Ranked value offered |
| out_ready | input | 1 | Downstream accepts; low stalls the whole block |
| out_data | output | W | Ranked value |

## Verification
A table of samples is streamed back-to-back while the rank is switched from sample to sample. The table includes ranks 0 and 7, repeated values, and values at 0 and full scale. This separates the ordering logic from the rank clamping and from the point at which each window's rank is latched. It also tests the exact latency and the one-per-clock cadence on every result. A second run inserts idle input cycles, which checks that the window survives gaps. A third run drops `out_ready` for several cycles in the middle of a stream, which shows whether results are held, lost or duplicated under stall. A final run resets the block with a partly filled window and confirms that stale samples never reach a result.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

  // Map an out-of-range rank onto the nearest legal one (1..n).
  function automatic int unsigned rank_clamp(input int unsigned r, input int unsigned n);
    if (r == 0) return 1;
    if (r > n) return n;
    return r;
  endfunction

endpackage

// File: rtl/rsf_window.sv
module rsf_window #(
  parameter int W  = 8,
  parameter int N  = 5,
  parameter int RW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           in_valid,
  input  logic [W-1:0]   in_data,
  input  logic [RW-1:0]  in_rank,
  output logic [N*W-1:0] win_flat,
  output logic           win_vld,
  output logic [RW-1:0]  win_rank
);
  import rsf_pkg::*;

  localparam int FW = $clog2(N + 1);

  logic [W-1:0]  taps_q [N];
  logic [FW-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q   <= '0;
      win_vld  <= 1'b0;
      win_rank <= '0;
      for (int i = 0; i < N; i++) taps_q[i] <= '0;
    end else if (en) begin
      if (in_valid) begin
        taps_q[0] <= in_data;
        for (int i = 1; i < N; i++) taps_q[i] <= taps_q[i-1];
        if (fill_q < FW'(N)) fill_q <= fill_q + FW'(1);
        win_vld  <= (fill_q >= FW'(N - 1));
        win_rank <= RW'(rank_clamp(int'(in_rank), N));
      end else begin
        win_vld <= 1'b0;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_flat
      assign win_flat[g*W +: W] = taps_q[g];
    end
  endgenerate

endmodule

// File: rtl/rsf_unit.sv
module rsf_unit #(
  parameter int W  = 8,
  parameter int N  = 5,
  parameter int RW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           start,
  input  logic [N*W-1:0] win_flat,
  input  logic [RW-1:0]  rank,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   result
);
  localparam int CW = $clog2(N + 1);
  localparam int LW = $clog2(W + 1);

  logic [W-1:0]  sh_q [N];
  logic [N-1:0]  fix_q, fv_q, fix_d, eff;
  logic [CW-1:0] thr_q, thr_c, ones;
  logic [W-1:0]  res_q;
  logic [LW-1:0] left_q;
  logic          ybit;

  // One bit step, MSB first. An element whose prefix already differs from
  // the result prefix is frozen at the bit that made it differ.
  always_comb begin
    thr_c = start ? CW'(N - int'(rank) + 1) : thr_q;
    ones  = '0;
    for (int i = 0; i < N; i++) begin
      if (start) eff[i] = win_flat[i*W + W - 1];
      else       eff[i] = fix_q[i] ? fv_q[i] : sh_q[i][W-1];
      ones = ones + {{(CW-1){1'b0}}, eff[i]};
    end
    ybit = (ones >= thr_c);
    for (int i = 0; i < N; i++) begin
      fix_d[i] = ((!start) && fix_q[i]) || (eff[i] != ybit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fix_q  <= '0;
      fv_q   <= '0;
      thr_q  <= '0;
      res_q  <= '0;
      left_q <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      for (int i = 0; i < N; i++) sh_q[i] <= '0;
    end else if (en) begin
      done <= 1'b0;
      if (start) begin
        for (int i = 0; i < N; i++) sh_q[i] <= {win_flat[i*W +: W-1], 1'b0};
        fix_q  <= fix_d;
        fv_q   <= eff;
        thr_q  <= thr_c;
        res_q  <= {{(W-1){1'b0}}, ybit};
        left_q <= LW'(W - 1);
        busy   <= 1'b1;
      end else if (busy) begin
        for (int i = 0; i < N; i++) sh_q[i] <= {sh_q[i][W-2:0], 1'b0};
        fix_q  <= fix_d;
        fv_q   <= eff;
        res_q  <= {res_q[W-2:0], ybit};
        left_q <= left_q - LW'(1);
        if (left_q == LW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign result = res_q;

endmodule

// File: rtl/rsf_collect.sv
module rsf_collect #(
  parameter int W = 8,
  parameter int U = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [U-1:0]   done_vec,
  input  logic [U*W-1:0] res_flat,
  output logic           out_valid,
  output logic [W-1:0]   out_data
);
  logic [W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int u = 0; u < U; u++) begin
      pick = pick | (res_flat[u*W +: W] & {W{done_vec[u]}});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (en) begin
      out_valid <= |done_vec;
      out_data  <= pick;
    end
  end

endmodule

// File: rtl/rank_stream_filter.sv
module rank_stream_filter #(
  parameter int W = 8,
  parameter int N = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [W-1:0]             in_data,
  input  logic [$clog2(N+1)-1:0]   in_rank,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [W-1:0]             out_data
);
  localparam int U  = W;
  localparam int RW = $clog2(N + 1);
  localparam int PW = (U > 1) ? $clog2(U) : 1;

  logic           en;
  logic [N*W-1:0] win_flat;
  logic           win_vld;
  logic [RW-1:0]  win_rank;
  logic [PW-1:0]  ptr;
  logic [U-1:0]   start_vec, busy_vec, done_vec;
  logic [U*W-1:0] res_flat;

  assign en       = out_ready;
  assign in_ready = out_ready;

  rsf_window #(.W(W), .N(N), .RW(RW)) u_win (
    .clk(clk), .rst_n(rst_n), .en(en),
    .in_valid(in_valid), .in_data(in_data), .in_rank(in_rank),
    .win_flat(win_flat), .win_vld(win_vld), .win_rank(win_rank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (en && win_vld) ptr <= (ptr == PW'(U - 1)) ? '0 : ptr + PW'(1);
  end

  genvar u;
  generate
    for (u = 0; u < U; u++) begin : g_unit
      assign start_vec[u] = win_vld && (ptr == PW'(u));
      rsf_unit #(.W(W), .N(N), .RW(RW)) u_sel (
        .clk(clk), .rst_n(rst_n), .en(en), .start(start_vec[u]),
        .win_flat(win_flat), .rank(win_rank),
        .busy(busy_vec[u]), .done(done_vec[u]), .result(res_flat[u*W +: W])
      );
    end
  endgenerate

  rsf_collect #(.W(W), .U(U)) u_col (
    .clk(clk), .rst_n(rst_n), .en(en),
    .done_vec(done_vec), .res_flat(res_flat),
    .out_valid(out_valid), .out_data(out_data)
  );

endmodule

// File: rtl/rsf_checker.sv
module rsf_checker #(
  parameter int W  = 8,
  parameter int U  = 8,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_ready,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic [U-1:0]  done_vec,
  input logic [U-1:0]  busy_vec,
  input logic          win_vld,
  input logic [PW-1:0] ptr
);

  a_r4_one_done: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_vec));

  a_r4_unit_free: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && out_ready) |-> !busy_vec[ptr]);

  a_r4_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && out_ready) |=>
      (int'(ptr) == ((int'($past(ptr)) == U - 1) ? 0 : int'($past(ptr)) + 1)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r5_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> !win_vld);

endmodule

bind rank_stream_filter rsf_checker #(.W(W), .U(U), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
  .done_vec(done_vec), .busy_vec(busy_vec), .win_vld(win_vld), .ptr(ptr)
);

// File: tb/rank_stream_filter_test.sv
module rank_stream_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 5;
  localparam int LAT = W + 1;
  localparam int NV = 24;
  // {rank[2:0], sample[7:0]}
  localparam logic [10:0] VEC [NV] = '{
    {3'd3, 8'd10}, {3'd3, 8'd200}, {3'd3, 8'd45}, {3'd3, 8'd7},  {3'd3, 8'd99},
    {3'd1, 8'd0},  {3'd5, 8'd255}, {3'd2, 8'd128},{3'd4, 8'd127},{3'd0, 8'd64},
    {3'd7, 8'd64}, {3'd6, 8'd64},  {3'd3, 8'd64}, {3'd3, 8'd64}, {3'd2, 8'd64},
    {3'd1, 8'd255},{3'd5, 8'd0},   {3'd3, 8'd1},  {3'd4, 8'd254},{3'd2, 8'd3},
    {3'd3, 8'd3},  {3'd5, 8'd200}, {3'd1, 8'd17}, {3'd3, 8'd88}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_data = '0;
  logic [2:0] in_rank = 3'd3;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [W-1:0] out_data;

  rank_stream_filter #(.W(W), .N(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_rank(in_rank), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, pc = 0, nout = 0;
  bit finished = 1'b0;
  bit prev_stall = 1'b0;
  logic [W-1:0] held;
  logic [W-1:0] mw [N];
  int mfill = 0;
  logic [W-1:0] expq [$];
  int expt [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_rank(input int r);
    logic [W-1:0] s [N];
    logic [W-1:0] t;
    int rr;
    for (int i = 0; i < N; i++) s[i] = mw[i];
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N - 1; j++)
        if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
    rr = (r == 0) ? 1 : ((r > N) ? N : r);
    return s[rr-1];
  endfunction

  task automatic step(input bit v, input logic [W-1:0] d, input logic [2:0] r,
                      input bit rdy, input bit chklat);
    logic [W-1:0] e;
    int t;
    @(negedge clk);
    if (prev_stall) chk(out_valid && out_data == held, "R6 held output", int'(out_data), int'(held));
    out_ready = rdy;
    if (!rdy) chk(in_ready == 1'b0, "R6 in_ready", int'(in_ready), 0);
    prev_stall = out_valid && !rdy;
    held = out_data;
    if (out_valid && rdy) begin
      nout++;
      if (expq.size() == 0) begin
        chk(1'b0, "R5 unexpected result", int'(out_data), -1);
      end else begin
        e = expq.pop_front();
        t = expt.pop_front();
        chk(out_data == e, "R1 ranked value", int'(out_data), int'(e));
        if (chklat) chk(pc - t == LAT, "R3/R4 latency", pc - t, LAT);
      end
    end
    in_valid = v; in_data = d; in_rank = r;
    @(posedge clk);
    pc++;
    if (v && rdy) begin
      for (int i = N - 1; i > 0; i--) mw[i] = mw[i-1];
      mw[0] = d;
      if (mfill < N) mfill++;
      if (mfill == N) begin
        expq.push_back(ref_rank(int'(r)));
        expt.push_back(pc);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    prev_stall = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    mfill = 0;
    expq.delete();
    expt.delete();
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 3'd3, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int base;
    do_reset();
    chk(in_ready == out_ready, "R6 in_ready mirrors out_ready", int'(in_ready), int'(out_ready));

    // Table walk: back-to-back, rank changing per sample (R1 R2 R8 R9)
    for (int k = 0; k < NV; k++) step(1'b1, VEC[k][7:0], VEC[k][10:8], 1'b1, 1'b1);
    flush(LAT + 3);
    chk(expq.size() == 0, "R4 all windows returned", expq.size(), 0);
    chk(nout == NV - N + 1, "R4 result count", nout, NV - N + 1);

    // Idle gaps keep the window (R5)
    for (int k = 0; k < 12; k++) begin
      step(1'b1, 8'(k * 37 + 5), 3'(1 + k % 5), 1'b1, 1'b1);
      if (k % 3 == 1) step(1'b0, '0, 3'd3, 1'b1, 1'b1);
    end
    flush(LAT + 3);
    chk(expq.size() == 0, "R5 gap results", expq.size(), 0);

    // Stall in the middle of a stream (R6)
    for (int k = 0; k < 30; k++) begin
      bit rdy;
      rdy = !((k >= 12 && k < 16) || k == 20 || k == 21);
      step(1'b1, 8'(k * 53 + 11), 3'(k % 8), rdy, 1'b0);
    end
    for (int k = 0; k < LAT + 4; k++) step(1'b0, '0, 3'd3, 1'b1, 1'b0);
    chk(expq.size() == 0, "R6 nothing lost in stall", expq.size(), 0);

    // Reset with partial fill (R7, R5)
    step(1'b1, 8'd250, 3'd5, 1'b1, 1'b1);
    step(1'b1, 8'd251, 3'd5, 1'b1, 1'b1);
    step(1'b1, 8'd252, 3'd5, 1'b1, 1'b1);
    do_reset();
    base = nout;
    for (int k = 0; k < 4; k++) step(1'b1, 8'(k + 1), 3'd5, 1'b1, 1'b1);
    flush(LAT + 3);
    chk(nout == base, "R5 no result before five samples", nout - base, 0);
    step(1'b1, 8'd9, 3'd5, 1'b1, 1'b1);
    flush(LAT + 3);
    chk(nout == base + 1 && expq.size() == 0, "R7 fresh window only", nout - base, 1);

    // All-equal window at both extremes (R9)
    for (int k = 0; k < 6; k++) step(1'b1, 8'd255, 3'(1 + k % 5), 1'b1, 1'b1);
    for (int k = 0; k < 6; k++) step(1'b1, 8'd0, 3'd5, 1'b1, 1'b1);
    flush(LAT + 3);
    chk(expq.size() == 0, "R9 extremes drained", expq.size(), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule